// File: doc/BRIEF.md
# Wide-Microword Sequencer with Opcode Dispatch

This block steps a horizontally microcoded processor through its control store. It holds a microcode ROM built from a constant function, a microaddress register, and the logic that picks the next microaddress. There is no microprogram counter. Every microword names its own successor address and its own flow-control choice, so microinstructions can be placed anywhere in the store and cost nothing to reach. The flow choices are: go to the address field, take a two-way branch on a selected condition input, dispatch on the incoming opcode, or stay where it is.

Opcode dispatch lands on the opcode's own value, so opcode N begins at microaddress N. Because the low 256 words are entry points, a word there never carries flow control of its own. The sequencer always treats it as an unconditional jump to its address field, which is where the rest of that opcode's microcode lives.

Each microword also selects how long it lasts: one, two or three clocks of the single base clock. A stretch counter holds the microaddress until the selected length has passed. A cycle-done strobe marks the last base clock of every microinstruction. The control field of the current word is presented at the output for the datapath. A two-way branch whose target is its own address gives a one-word loop.

Top module: `useq_dispatch`

## Requirements
- R1: While the reset input is low the microaddress is 0x100 and the stretch count is cleared. Asserting reset takes effect at once, without a clock. After reset is released the microaddress holds 0x100 through two more rising edges and first advances on the third.
- R2: The 2-bit cycle field selects the length of a microinstruction: 00 is one base clock, 01 is two, and 10 or 11 is three. The cycle-done output is high on the last base clock of a microinstruction and low on all the others.
- R3: The microaddress changes only on a rising edge where cycle-done is high. On every other edge it keeps its value.
- R4: Flow code 00 (goto) at an address of 256 or more loads the 9-bit address field.
- R5: Flow code 01 (branch) at an address of 256 or more loads the address field with its bit 0 replaced by the condition input chosen by the 2-bit select field.
- R6: Flow code 10 (dispatch) loads {0, opcode}, taking the opcode input at the edge that ends the microinstruction.
- R7: Flow code 11 (hold) keeps the current microaddress.
- R8: At any address below 256 the flow code is ignored and the word acts as a goto to its address field.
- R9: A branch word whose computed target equals its own address repeats for as long as the selected condition keeps that target.
- R10: The microword is 31 bits: address [8:0], flow [10:9], condition select [12:11], cycle [14:13], control [30:15]. The control output equals the control field of the word at the current microaddress.
- R11: Contents, with control = {a[6:0], a} for every address a. For a < 256: flow 11 (ignored), cycle a[3:2], target 0x108 if a = 255, otherwise 0x100 + a[1:0]. At 0x100: dispatch, cycle 00. At 0x101: goto 0x100, cycle 01. At 0x102: branch on condition 0 to 0x104/0x105, cycle 00. At 0x103: goto 0x107, cycle 10. At 0x104: goto 0x100, cycle 10. At 0x105: goto 0x100, cycle 11. At 0x106: goto 0x100, cycle 00. At 0x107: branch on condition 1 to 0x106/0x107, cycle 00. At 0x108: hold, cycle 01. Every other address: goto 0x100, cycle 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode_i | input | 8 | Opcode used by a dispatch word |
| cond_i | input | 4 | Condition inputs for two-way branches |
| uaddr_o | output | 9 | Current microaddress |
| ctl_o | output | 16 | Control field of the current microword |
| cyc_done_o | output | 1 | High on the last base clock of a microinstruction |

## Verification
The assertions assume that the opcode and condition inputs are settled at each rising edge and that reset is the only thing that disturbs the register state. They also assume that only the edge where cycle-done is high samples the opcode and the selected condition. The bench changes inputs only at falling edges. During stretched cycles it drives the opcode with its complement and toggles the unused condition bits, so that a sample taken on the wrong edge would show up at the outputs. It sweeps every dispatchable opcode against all four settings of the two used conditions. A counted pulse on condition 1 keeps the one-word loop bounded.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UA_W  = 9;
  localparam int OP_W  = 8;
  localparam int CTL_W = 16;
  localparam int NCOND = 4;
  localparam int SEL_W = $clog2(NCOND);
  localparam int CYC_W = 2;

  typedef enum logic [1:0] {
    FL_GOTO = 2'b00,
    FL_COND = 2'b01,
    FL_DISP = 2'b10,
    FL_HOLD = 2'b11
  } flow_e;

  typedef struct packed {
    logic [CTL_W-1:0] ctl;
    logic [CYC_W-1:0] cyc;
    logic [SEL_W-1:0] sel;
    flow_e            flow;
    logic [UA_W-1:0]  nxt;
  } uword_t;

  localparam logic [UA_W-1:0] FETCH_ADDR = UA_W'(9'h100);

  function automatic uword_t mk_word(input flow_e f, input logic [UA_W-1:0] n,
                                     input logic [SEL_W-1:0] s,
                                     input logic [CYC_W-1:0] c,
                                     input logic [UA_W-1:0] a);
    uword_t w;
    w.flow = f;
    w.nxt  = n;
    w.sel  = s;
    w.cyc  = c;
    w.ctl  = {a[6:0], a};
    return w;
  endfunction

  function automatic uword_t prog_word(input logic [UA_W-1:0] a);
    uword_t w;
    if (a[UA_W-1:OP_W] == '0) begin
      if (a[OP_W-1:0] == '1)
        w = mk_word(FL_HOLD, 9'h108, '0, a[3:2], a);
      else
        w = mk_word(FL_HOLD, FETCH_ADDR + UA_W'(a[1:0]), '0, a[3:2], a);
    end else begin
      case (a)
        9'h100:  w = mk_word(FL_DISP, 9'h000, 2'd0, 2'b00, a);
        9'h101:  w = mk_word(FL_GOTO, 9'h100, 2'd0, 2'b01, a);
        9'h102:  w = mk_word(FL_COND, 9'h104, 2'd0, 2'b00, a);
        9'h103:  w = mk_word(FL_GOTO, 9'h107, 2'd0, 2'b10, a);
        9'h104:  w = mk_word(FL_GOTO, 9'h100, 2'd0, 2'b10, a);
        9'h105:  w = mk_word(FL_GOTO, 9'h100, 2'd0, 2'b11, a);
        9'h106:  w = mk_word(FL_GOTO, 9'h100, 2'd0, 2'b00, a);
        9'h107:  w = mk_word(FL_COND, 9'h106, 2'd1, 2'b00, a);
        9'h108:  w = mk_word(FL_HOLD, 9'h000, 2'd0, 2'b01, a);
        default: w = mk_word(FL_GOTO, 9'h100, 2'd0, 2'b00, a);
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_no = sync_q;

endmodule

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int ADDR_W = UA_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output uword_t            word_o
);

  uword_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign mem[i] = prog_word(UA_W'(i));
  end

  assign word_o = mem[addr_i];

endmodule

// File: rtl/useq_stretch.sv
module useq_stretch #(
  parameter int SEL_BITS = 2,
  parameter int MAX_LEN  = 3,
  localparam int CNT_W   = $clog2(MAX_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_BITS-1:0] cyc_sel_i,
  output logic                done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_v;

  always_comb begin
    case (cyc_sel_i)
      SEL_BITS'(0): last_v = CNT_W'(0);
      SEL_BITS'(1): last_v = CNT_W'(1);
      default:      last_v = CNT_W'(MAX_LEN - 1);
    endcase
  end

  assign done_o = (cnt_q == last_v);

  always_comb begin
    if (done_o) cnt_d = '0;
    else        cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/useq_nextsel.sv
module useq_nextsel
  import useq_pkg::*;
#(
  parameter int ADDR_W = UA_W,
  parameter int OPC_W  = OP_W,
  parameter int COND_N = NCOND,
  localparam int CS_W  = $clog2(COND_N)
) (
  input  logic [ADDR_W-1:0] uaddr_i,
  input  logic [ADDR_W-1:0] nxt_i,
  input  flow_e             flow_i,
  input  logic [CS_W-1:0]   sel_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [COND_N-1:0] cond_i,
  output logic [ADDR_W-1:0] next_o
);

  localparam int HI_W = ADDR_W - OPC_W;

  logic  in_region;
  logic  cond_bit;
  flow_e eff_flow;

  assign in_region = (uaddr_i[ADDR_W-1:OPC_W] == '0);
  assign cond_bit  = cond_i[sel_i];
  assign eff_flow  = in_region ? FL_GOTO : flow_i;

  always_comb begin
    case (eff_flow)
      FL_GOTO: next_o = nxt_i;
      FL_COND: next_o = {nxt_i[ADDR_W-1:1], cond_bit};
      FL_DISP: next_o = {{HI_W{1'b0}}, opcode_i};
      default: next_o = uaddr_i;
    endcase
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int ADDR_W = UA_W,
  parameter int OPC_W  = OP_W,
  parameter int COND_N = NCOND,
  parameter int CW     = CTL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [COND_N-1:0] cond_i,
  output logic [ADDR_W-1:0] uaddr_o,
  output logic [CW-1:0]     ctl_o,
  output logic              cyc_done_o
);

  logic              rst_sync_n;
  logic [ADDR_W-1:0] uaddr_q;
  logic [ADDR_W-1:0] uaddr_d;
  logic [ADDR_W-1:0] next_addr;
  logic              cyc_done;
  uword_t            cur_word;

  logic [ADDR_W-1:0] cur_nxt;
  flow_e             cur_flow;
  logic [SEL_W-1:0]  cur_sel;
  logic [CYC_W-1:0]  cur_cyc;

  useq_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  useq_rom #(.ADDR_W(ADDR_W)) u_rom (
    .addr_i (uaddr_q),
    .word_o (cur_word)
  );

  assign cur_nxt  = cur_word.nxt;
  assign cur_flow = cur_word.flow;
  assign cur_sel  = cur_word.sel;
  assign cur_cyc  = cur_word.cyc;

  useq_stretch #(.SEL_BITS(CYC_W), .MAX_LEN(3)) u_stretch (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .cyc_sel_i (cur_cyc),
    .done_o    (cyc_done)
  );

  useq_nextsel #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .COND_N(COND_N)) u_nextsel (
    .uaddr_i  (uaddr_q),
    .nxt_i    (cur_nxt),
    .flow_i   (cur_flow),
    .sel_i    (cur_sel),
    .opcode_i (opcode_i),
    .cond_i   (cond_i),
    .next_o   (next_addr)
  );

  always_comb begin
    if (cyc_done) uaddr_d = next_addr;
    else          uaddr_d = uaddr_q;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) uaddr_q <= FETCH_ADDR;
    else             uaddr_q <= uaddr_d;
  end

  assign uaddr_o    = uaddr_q;
  assign ctl_o      = cur_word.ctl;
  assign cyc_done_o = cyc_done;

endmodule

// File: rtl/useq_dispatch_chk.sv
module useq_dispatch_chk #(
  parameter int ADDR_W = 9,
  parameter int OPC_W  = 8,
  parameter int COND_N = 4,
  localparam int CS_W  = $clog2(COND_N)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] uaddr,
  input logic              done,
  input logic [ADDR_W-1:0] nxt,
  input logic [1:0]        flow,
  input logic [CS_W-1:0]   sel,
  input logic [1:0]        cyc,
  input logic [OPC_W-1:0]  opcode,
  input logic [COND_N-1:0] cond
);

  logic       in_reg;
  logic       cbit;
  logic [1:0] run_q;
  logic [1:0] len_m1;

  assign in_reg = (uaddr[ADDR_W-1:OPC_W] == '0);
  assign cbit   = cond[sel];
  assign len_m1 = (cyc == 2'b00) ? 2'd0 : ((cyc == 2'b01) ? 2'd1 : 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= 2'd0;
    else if (done) run_q <= 2'd0;
    else           run_q <= run_q + 2'd1;
  end

  p_len_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 2'd2);

  p_len_exact_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> (run_q == len_m1));

  p_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(uaddr));

  p_goto_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !in_reg && flow == 2'b00) |=> (uaddr == $past(nxt)));

  p_branch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !in_reg && flow == 2'b01) |=>
      (uaddr == {$past(nxt[ADDR_W-1:1]), $past(cbit)}));

  p_dispatch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !in_reg && flow == 2'b10) |=>
      (uaddr == ADDR_W'($past(opcode))));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !in_reg && flow == 2'b11) |=> $stable(uaddr));

  p_forced_goto_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && in_reg) |=> (uaddr == $past(nxt)));

  p_self_loop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !in_reg && flow == 2'b01 && {nxt[ADDR_W-1:1], cbit} == uaddr)
      |=> $stable(uaddr));

endmodule

bind useq_dispatch useq_dispatch_chk #(
  .ADDR_W (ADDR_W),
  .OPC_W  (OPC_W),
  .COND_N (COND_N)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_sync_n),
  .uaddr  (uaddr_q),
  .done   (cyc_done),
  .nxt    (cur_nxt),
  .flow   (cur_flow),
  .sel    (cur_sel),
  .cyc    (cur_cyc),
  .opcode (opcode_i),
  .cond   (cond_i)
);

// File: tb/useq_dispatch_tb_top.sv
module useq_dispatch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk;
  logic       rst_n;
  logic [7:0] opcode;
  logic [3:0] cond;
  logic [8:0] uaddr;
  logic [15:0] ctl;
  logic       done;

  int    n_checks;
  int    n_errors;
  int    m_addr;
  int    m_cnt;
  int    stay;
  string m_why;
  bit    finished;

  useq_dispatch dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .opcode_i   (opcode),
    .cond_i     (cond),
    .uaddr_o    (uaddr),
    .ctl_o      (ctl),
    .cyc_done_o (done)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // Program contents as listed in R11; fields as laid out in R10.
  function automatic void bprog(input int a, output int nxt, output int flow,
                                output int sel, output int cyc, output int c);
    c = ((a & 127) << 9) | a;
    sel = 0;
    if (a < 256) begin
      flow = 3;
      cyc  = (a >> 2) & 3;
      nxt  = (a == 255) ? 'h108 : 'h100 + (a & 3);
    end else begin
      case (a)
        'h100: begin flow = 2; nxt = 0;     cyc = 0; end
        'h101: begin flow = 0; nxt = 'h100; cyc = 1; end
        'h102: begin flow = 1; nxt = 'h104; cyc = 0; end
        'h103: begin flow = 0; nxt = 'h107; cyc = 2; end
        'h104: begin flow = 0; nxt = 'h100; cyc = 2; end
        'h105: begin flow = 0; nxt = 'h100; cyc = 3; end
        'h106: begin flow = 0; nxt = 'h100; cyc = 0; end
        'h107: begin flow = 1; nxt = 'h106; cyc = 0; sel = 1; end
        'h108: begin flow = 3; nxt = 0;     cyc = 1; end
        default: begin flow = 0; nxt = 'h100; cyc = 0; end
      endcase
    end
  endfunction

  function automatic int blen(input int cyc);
    return (cyc == 0) ? 1 : ((cyc == 1) ? 2 : 3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    int nx, fl, sl, cy, cc;
    bprog(m_addr, nx, fl, sl, cy, cc);
    chk(m_why, int'(uaddr), m_addr);
    chk("R2 done", int'(done), (m_cnt == blen(cy) - 1) ? 1 : 0);
    chk("R10 ctl", int'(ctl), cc);
  endtask

  task automatic step_model();
    int nx, fl, sl, cy, cc, tgt, cb;
    bprog(m_addr, nx, fl, sl, cy, cc);
    if (m_cnt != blen(cy) - 1) begin
      m_cnt++;
      m_why = "R3 stable";
    end else begin
      m_cnt = 0;
      if (m_addr < 256) begin
        m_addr = nx;
        m_why  = "R8 forced goto";
      end else begin
        case (fl)
          0: begin m_addr = nx; m_why = "R4 goto"; end
          1: begin
            cb  = int'(cond[sl]);
            tgt = (nx & ~1) | cb;
            m_why  = (tgt == m_addr) ? "R9 self loop" : "R5 branch";
            m_addr = tgt;
          end
          2: begin m_addr = int'(opcode); m_why = "R6 dispatch"; end
          default: m_why = "R7 hold";
        endcase
      end
    end
  endtask

  task automatic model_reset();
    m_addr = 'h100;
    m_cnt  = 0;
    m_why  = "R1 reset";
  endtask

  // Entered and left at a falling edge.
  task automatic run_op(input logic [7:0] op, input int pat, input int maxc);
    stay = 0;
    for (int c = 0; c < maxc; c++) begin
      check_outputs();
      if (c > 0 && m_addr == 'h100) break;
      opcode  = (m_addr == 'h100) ? op : ~op;
      cond[0] = pat[0];
      cond[1] = pat[1] && (stay < 3);
      cond[3:2] = 2'(c);
      if (m_addr == 'h107) stay++;
      step_model();
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
      finish_run();
    end
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    finished = 1'b0;
    rst_n  = 1'b0;
    opcode = 8'h00;
    cond   = 4'h0;
    model_reset();
    // R1: reset state, held across several edges
    repeat (3) begin
      @(negedge clk);
      opcode = opcode + 8'h37;
      check_outputs();
    end
    rst_n = 1'b1;
    // R1: two more edges stay at the entry before advancing
    @(negedge clk);
    check_outputs();
    @(negedge clk);
    check_outputs();

    // R4..R9 with R2/R3/R10 on every cycle: all opcodes, all condition pairs
    for (int op = 0; op < 255; op++) begin
      for (int pat = 0; pat < 4; pat++) begin
        run_op(8'(op), pat, 40);
      end
    end

    // R7: opcode 255 ends in the hold word
    run_op(8'hFF, 0, 20);
    chk("R7 hold reached", m_addr, 'h108);

    // R1: asynchronous reset in the middle of a stretched hold word
    rst_n = 1'b0;
    #1;
    model_reset();
    chk("R1 async addr", int'(uaddr), 'h100);
    chk("R1 async done", int'(done), 1);
    @(negedge clk);
    check_outputs();
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();
    @(negedge clk);
    check_outputs();
    run_op(8'h03, 3, 40);
    run_op(8'h0E, 1, 40);

    finished = 1'b1;
    finish_run();
  end

endmodule